// File: doc/BRIEF.md
# Capture/Compare Timer Channel

A single up/down timer channel driven through a small word-addressed register port. In compare mode it runs from a preloaded value. When it passes the top of its range (counting up) or the bottom (counting down), it raises a sticky event flag. It then either stops at the terminal value or restarts from the preload value. In capture mode the running count is copied into the preload register whenever a rising edge is seen on an asynchronous capture pin. That pin is first synchronised.

Software programs a control word, a preload value, and reads back the live count. A level interrupt is the event flag masked by an enable bit. A one-clock generate pulse marks each compare event.

Register word offsets (byte address bits [3:2]): 0 control/status, 1 preload/capture, 2 live count (read only).

Top module: `cc_timer_chan`

## Requirements
- R1: After reset, all three registers read zero and both `irq` and `gen_out` are low.
- R2: Control bits [8:0] read back at byte address 0, with bits 31:9 always zero. The preload register reads back at address 4 and the count at address 8. Writes to address 8 have no effect.
- R3: While control bit 5 (load) is set, each clock copies the preload register into the count. This takes priority over counting, even with bit 7 (enable) set.
- R4: With bit 7 set and bit 5 clear, the count moves by one per clock: up when bit 1 is 0, down when bit 1 is 1. With bit 7 clear it stays put.
- R5: In compare mode (bit 0 clear), a compare event happens on the clock where the count is all ones counting up, or zero counting down. That clock sets the flag at control bit 8.
- R6: With bit 4 (auto-reload) clear, a compare event freezes the count at its terminal value until the next load.
- R7: With bit 4 set, a compare event copies the preload value into the count and counting continues.
- R8: Writing control with bit 8 = 1 clears the flag; writing bit 8 = 0 leaves it unchanged. A new event in the same clock as a clearing write leaves the flag set.
- R9: `irq` equals the flag ANDed with control bit 6.
- R10: With bit 2 set, `gen_out` is high for exactly the one clock after each compare event. It is never high in capture mode.
- R11: In capture mode (bit 0 set) with bit 3 set, a rising edge on `cap_in` stores the count into the preload register and sets the flag. `cap_in` passes through two synchronising flops and an edge detector. The stored value is the count present two clocks after `cap_in` was raised at a clock boundary. A held-high input captures only once.
- R12: In capture mode with bit 4 clear, a capture that arrives while the flag is set is dropped. With bit 4 set, every capture overwrites the previous value.
- R13: With bit 3 clear, `cap_in` changes neither the preload register nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this clock |
| addr | input | ADDR_W (4) | Byte address for both read and write |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| cap_in | input | 1 | Asynchronous capture request |
| irq | output | 1 | Level interrupt |
| gen_out | output | 1 | One-clock pulse per compare event |

## Verification
Compare mode is run twice. Counting up with hold uses a preload just below all ones, which shows where the roll-over is detected and that the count then freezes. Counting down with reload uses a small preload, so repeated roll-unders show the restart value and a regular generate-pulse rhythm. That run also lines a clearing write up with an event to expose the priority. Capture mode is run with a held-high pin in overwrite mode to separate edge detection from level sensing. It is then run in hold mode, with captures before and after acknowledgment, to tell dropping apart from overwriting. A final run with the capture-enable bit clear shows the pin is ignored.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    // Control fields; packed order puts cap_mode at bit 0 .. tmr_en at bit 7
    typedef struct packed {
        logic tmr_en;    // bit 7
        logic irq_en;    // bit 6
        logic load;      // bit 5
        logic auto_rld;  // bit 4
        logic cap_en;    // bit 3
        logic gen_en;    // bit 2
        logic down;      // bit 1
        logic cap_mode;  // bit 0
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int FLAG_BIT  = CTRL_BITS;

    // word indices within the register window
    localparam logic [1:0] WIDX_CTRL = 2'd0;
    localparam logic [1:0] WIDX_LOAD = 2'd1;
    localparam logic [1:0] WIDX_CNT  = 2'd2;

endpackage

// File: rtl/cct_capsync.sv
module cct_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], cap_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.sync[STAGES-1] & ~st_q.prev;

    // one assertion of the pin gives a single-cycle edge
    p_one_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/cct_counter.sv
module cct_counter
    import cc_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctrl_t        ctrl_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         cmp_evt_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         halt;
    } st_t;

    st_t  st_d, st_q;
    logic run, at_term, evt;

    always_comb begin
        run     = ctrl_i.tmr_en & ~ctrl_i.load & ~st_q.halt;
        at_term = ctrl_i.down ? (st_q.cnt == '0) : (st_q.cnt == ALL_ONES);
        evt     = run & ~ctrl_i.cap_mode & at_term;

        st_d = st_q;
        if (ctrl_i.load) begin
            st_d.cnt  = load_val_i;
            st_d.halt = 1'b0;
        end else if (evt) begin
            if (ctrl_i.auto_rld) st_d.cnt  = load_val_i;
            else                 st_d.halt = 1'b1;
        end else if (run) begin
            st_d.cnt = ctrl_i.down ? st_q.cnt - W'(1) : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign cmp_evt_o = evt;

    p_load_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_i.load |=> cnt_o == $past(load_val_i));

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl_i.down && !evt) |=> cnt_o == $past(cnt_o) + W'(1));

    p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl_i.down && !evt) |=> cnt_o == $past(cnt_o) - W'(1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.halt && !ctrl_i.load) |=> $stable(cnt_o));

endmodule

// File: rtl/cct_regs.sv
module cct_regs
    import cc_timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl_i,
    input  logic         wr_load_i,
    input  logic [W-1:0] wdata_i,
    input  logic         cap_edge_i,
    input  logic         cmp_evt_i,
    input  logic [W-1:0] cnt_i,
    output ctrl_t        ctrl_o,
    output logic [W-1:0] load_o,
    output logic         flag_o,
    output logic         gen_o
);
    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] load;
        logic         flag;
        logic         gen;
    } st_t;

    st_t  st_d, st_q;
    logic cap_ok, cap_take, clr_req;

    always_comb begin
        cap_ok   = st_q.ctrl.cap_mode & st_q.ctrl.cap_en & cap_edge_i;
        cap_take = cap_ok & (st_q.ctrl.auto_rld | ~st_q.flag);
        clr_req  = wr_ctrl_i & wdata_i[FLAG_BIT];

        st_d = st_q;
        if (wr_ctrl_i) st_d.ctrl = ctrl_t'(wdata_i[CTRL_BITS-1:0]);

        // a capture takes precedence over a software write of the same word
        if (cap_take)       st_d.load = cnt_i;
        else if (wr_load_i) st_d.load = wdata_i;

        if (clr_req)            st_d.flag = 1'b0;
        if (cmp_evt_i | cap_ok) st_d.flag = 1'b1;

        st_d.gen = cmp_evt_i & st_q.ctrl.gen_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign load_o = st_q.load;
    assign flag_o = st_q.flag;
    assign gen_o  = st_q.gen;

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !cmp_evt_i && !cap_ok) |=> !flag_o);

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt_i |=> flag_o);

    p_cap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && st_q.ctrl.cap_mode && !st_q.ctrl.auto_rld && !wr_load_i)
        |=> $stable(load_o));

endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
    import cc_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_in,
    output logic              irq,
    output logic              gen_out
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              wr_ctrl, wr_load;
    logic              cap_edge, cmp_evt, flag;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] load_val, cnt;
    logic              unused_abits;

    assign widx         = addr[ADDR_W-1:2];
    assign unused_abits = ^addr[1:0];
    assign wr_ctrl      = wr_en && (widx == WIDX_W'(WIDX_CTRL));
    assign wr_load      = wr_en && (widx == WIDX_W'(WIDX_LOAD));

    cct_capsync #(.STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap_in),
        .edge_o (cap_edge)
    );

    cct_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .cmp_evt_o  (cmp_evt)
    );

    cct_regs #(.W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl_i  (wr_ctrl),
        .wr_load_i  (wr_load),
        .wdata_i    (wdata),
        .cap_edge_i (cap_edge),
        .cmp_evt_i  (cmp_evt),
        .cnt_i      (cnt),
        .ctrl_o     (ctrl),
        .load_o     (load_val),
        .flag_o     (flag),
        .gen_o      (gen_out)
    );

    always_comb begin
        rdata = '0;
        if (widx == WIDX_W'(WIDX_CTRL))      rdata = DATA_W'({flag, ctrl});
        else if (widx == WIDX_W'(WIDX_LOAD)) rdata = load_val;
        else if (widx == WIDX_W'(WIDX_CNT))  rdata = cnt;
    end

    assign irq = flag & ctrl.irq_en;

    p_gen_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gen_out |-> flag);

    p_gen_nocap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cap_mode && $past(ctrl.cap_mode)) |-> !gen_out);

endmodule

// File: tb/sim_cc_timer_chan.sv
module sim_cc_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cap_in = 1'b0;
    logic        irq, gen_out;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    cc_timer_chan u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .irq(irq), .gen_out(gen_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    // preload, pulse the load bit, then install the final control word
    task automatic preload(input logic [31:0] v, input logic [31:0] c);
        wr(4'h4, v);
        wr(4'h0, 32'h20);
        wr(4'h0, c);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 0);
        rd(4'h4, v); chk("R1 load", v, 0);
        rd(4'h8, v); chk("R1 count", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 gen", gen_out, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(4'h4, 32'h1234_5678);
        rd(4'h4, v); chk("R2 load readback", v, 32'h1234_5678);
        wr(4'h0, 32'h0000_0E02);
        rd(4'h0, v); chk("R2 reserved bits zero", v, 32'h0000_0002);
        wr(4'h8, 32'hDEAD_BEEF);
        rd(4'h8, v); chk("R2 count write ignored", v, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_load_prio;
        logic [31:0] v;
        wr(4'h4, 32'd100);
        wr(4'h0, 32'hA0);
        tick(3);
        rd(4'h8, v); chk("R3 load beats enable", v, 32'd100);
        wr(4'h0, 32'h80);
        rd(4'h8, v); chk("R3 last load edge", v, 32'd100);
        tick(2);
        rd(4'h8, v); chk("R4 up count", v, 32'd102);
        wr(4'h0, 32'h00);
        tick(3);
        rd(4'h8, v); chk("R4 disabled holds", v, 32'd103);
    endtask

    task automatic t_cmp_up_hold;
        logic [31:0] v;
        preload(32'hFFFF_FFFD, 32'h84);
        tick(2);
        rd(4'h8, v); chk("R4 near top", v, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R5 no early flag", v[8], 0);
        tick(1);
        rd(4'h0, v); chk("R5 flag on roll-over", v[8], 1);
        chk("R10 gen pulse", gen_out, 1);
        chk("R9 irq masked", irq, 0);
        tick(1);
        chk("R10 gen one clock", gen_out, 0);
        tick(3);
        rd(4'h8, v); chk("R6 holds at top", v, 32'hFFFF_FFFF);
        wr(4'h0, 32'hC4);
        rd(4'h0, v); chk("R8 zero write keeps flag", v[8], 1);
        chk("R9 irq on", irq, 1);
        wr(4'h0, 32'h1C4);
        rd(4'h0, v); chk("R8 one write clears", v[8], 0);
        chk("R9 irq off", irq, 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_cmp_down_reload;
        logic [31:0] v;
        preload(32'd2, 32'h96);
        tick(2);
        rd(4'h8, v); chk("R4 down count", v, 0);
        tick(1);
        rd(4'h8, v); chk("R7 reload on roll-under", v, 32'd2);
        rd(4'h0, v); chk("R5 flag down", v[8], 1);
        chk("R10 gen down", gen_out, 1);
        tick(1);
        rd(4'h8, v); chk("R7 keeps running", v, 32'd1);
        chk("R10 gen low", gen_out, 0);
        tick(1);
        wr(4'h0, 32'h196);
        rd(4'h0, v); chk("R8 event beats clear", v[8], 1);
        chk("R10 second pulse", gen_out, 1);
        wr(4'h0, 32'h196);
        rd(4'h0, v); chk("R8 clear without event", v[8], 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_cap_overwrite;
        logic [31:0] v, c;
        preload(32'd1000, 32'h9D);
        cap_in = 1'b1;
        tick(2);
        rd(4'h4, v); chk("R11 not yet captured", v, 32'd1000);
        tick(1);
        rd(4'h4, v); chk("R11 capture value", v, 32'd1002);
        rd(4'h0, v); chk("R11 flag on capture", v[8], 1);
        tick(4);
        rd(4'h4, v); chk("R11 single capture when held", v, 32'd1002);
        chk("R10 no gen in capture", gen_out, 0);
        cap_in = 1'b0;
        tick(3);
        rd(4'h8, c);
        cap_in = 1'b1;
        tick(3);
        rd(4'h4, v); chk("R12 overwrite with flag set", v, c + 32'd2);
        cap_in = 1'b0;
        tick(3);
    endtask

    task automatic t_cap_hold;
        logic [31:0] v, c, first;
        wr(4'h0, 32'h189);
        rd(4'h8, c);
        cap_in = 1'b1; tick(3); cap_in = 1'b0;
        first = c + 32'd2;
        rd(4'h4, v); chk("R11 capture in hold mode", v, first);
        tick(3);
        cap_in = 1'b1; tick(3); cap_in = 1'b0;
        rd(4'h4, v); chk("R12 held until ack", v, first);
        tick(3);
        wr(4'h0, 32'h189);
        rd(4'h8, c);
        cap_in = 1'b1; tick(3); cap_in = 1'b0;
        rd(4'h4, v); chk("R12 capture after ack", v, c + 32'd2);
        tick(3);
    endtask

    task automatic t_cap_disabled;
        logic [31:0] v, l;
        wr(4'h0, 32'h181);
        rd(4'h4, l);
        cap_in = 1'b1; tick(4); cap_in = 1'b0;
        rd(4'h4, v); chk("R13 load untouched", v, l);
        rd(4'h0, v); chk("R13 flag untouched", v[8], 0);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regmap();
        t_load_prio();
        t_cmp_up_hold();
        t_cmp_down_reload();
        t_cap_overwrite();
        t_cap_hold();
        t_cap_disabled();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule